// File: doc/BRIEF.md
# ONFI Parameter Page Decoder

This block turns a 256-byte parameter page, already held in a local byte store, into the figures a flash controller needs: device geometry, endurance, ECC needs and bus width. A single-cycle `start` pulse makes it walk the page one byte per cycle. It drives a byte index on `pg_addr` and takes the matching byte on `pg_data` in the same cycle. The store must answer combinationally. The block keeps only the fields it uses.

Once the last needed byte has been taken, two shift-add multipliers scale the per-LUN block count and the bad-block limit by the LUN count. At the same time a multiply-by-ten stepper expands the endurance mantissa by its decimal exponent. The block then loads every result register at once, raises `done` for one cycle and reports a single error code. Results stay put until the next completed run. A `start` that arrives while a run is under way is ignored.

Top module: `onfi_pdec`

## Requirements
- R1: While reset is low and after it is released, `done` is 0 and every result output (including `err`, `bus_width`, `copy_count`) reads 0.
- R2: Each accepted `start` yields exactly one `done` pulse one cycle wide. The result outputs change only in the cycle `done` is high, and they hold their values afterwards.
- R3: `sig_valid` is 1 only when page bytes 0, 1, 2 and 3 read 4Fh, 4Eh, 46h and 49h.
- R4: The revision word is little-endian in bytes 4 (low) and 5 (high). It is a version fault when bit 0 is set, or when no bit of `SUP_MASK` (default 007Eh, bits 1 to 6) is set. `copy_count` is byte 14 when any bit of `SUP_MASK` at position 3 or above is set in the word, and 3 otherwise.
- R5: In feature byte 6, bit 0 set gives `bus_width` = 16 and bit 0 clear gives 8. When bit 7 is set, `ext_page_len` = 16 × the little-endian word in bytes 12 and 13; when bit 7 is clear it is 0.
- R6: The following fields are taken little-endian and truncated to the output width: page size from bytes 80–83, spare size from 84–85, pages per block from 92–95. Programs per page comes from byte 110 and ECC bits from byte 112.
- R7: `total_blocks` = (bytes 96–99, low `BLK_W` bits) × byte 100. `total_bad_max` = (bytes 103–104) × byte 100.
- R8: `max_erase` = byte 105 × 10^(byte 106). An exponent above 9, or a product that does not fit in 32 bits, is a range fault and forces `max_erase` to 0.
- R9: It is a range fault when the page size is ≥ 2^`PGSZ_W`, the pages per block is ≥ 2^`PPB_W`, or the blocks per LUN is ≥ 2^`BLK_W`.
- R10: When ECC bits = FFh, `ecc_cw_size` is 0, and it is an extension fault if feature bit 7 is clear. Any other value gives `ecc_cw_size` = 528.
- R11: `err` codes: 0 none, 1 signature, 2 version, 3 range, 4 extension. When several faults apply, the one earliest in that list is reported.
- R12: `pg_addr` steps through 0..112 and never exceeds 112.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode run (used when idle) |
| pg_addr | output | 8 | Byte index into the parameter page |
| pg_data | input | 8 | Page byte at `pg_addr`, same cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Error code, see R11 |
| sig_valid | output | 1 | Signature matched |
| bus_width | output | 5 | 8 or 16 |
| page_size | output | PGSZ_W | Data bytes per page |
| spare_size | output | 16 | Spare bytes per page |
| pages_per_blk | output | PPB_W | Pages per block |
| total_blocks | output | BLK_W+8 | Blocks over all LUNs |
| total_bad_max | output | 24 | Bad-block limit over all LUNs |
| max_erase | output | 32 | Erase cycles per block |
| progs_per_page | output | 8 | Partial programs per page |
| ecc_bits | output | 8 | Correctable bits field |
| ecc_cw_size | output | 10 | ECC codeword size |
| copy_count | output | 8 | Parameter page copies |
| ext_page_len | output | 20 | Extended page length in bytes |

## Verification
The bench builds the block with its defaults: `PGSZ_W` = 16, `PPB_W` = 16, `BLK_W` = 20 and `SUP_MASK` = 007Eh. With these widths, a page size of 65536 or a blocks-per-LUN count of 2^20 sits just past the limit and is cheap to write into a page. That makes each range edge reachable on both sides. Endurance pairs such as 4×10^9 (fits) and 255×10^9 (overflows) test the 32-bit edge. Combining several faults in one page shows that the reported code follows the priority order.

// File: rtl/onfi_pdec_pkg.sv
package onfi_pdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MATH
    } pdec_state_e;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_SIG   = 3'd1,
        ERR_VER   = 3'd2,
        ERR_RANGE = 3'd3,
        ERR_EXT   = 3'd4
    } pdec_err_e;

    localparam logic [7:0] LAST_IDX  = 8'd112;
    localparam logic [9:0] CW_NORMAL = 10'd528;
    localparam int unsigned EXP_MAX  = 9;

    // expected signature character for byte k of the page
    function automatic logic [7:0] sig_char(input logic [1:0] k);
        case (k)
            2'd0:    return 8'h4F;
            2'd1:    return 8'h4E;
            2'd2:    return 8'h46;
            default: return 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/pdec_mul.sv
// Sequential shift-add multiplier: one multiplier bit per cycle.
module pdec_mul #(
    parameter int AW = 20,
    parameter int BW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [AW-1:0]      a,
    input  logic [BW-1:0]      b,
    output logic [AW+BW-1:0]   prod,
    output logic               busy
);
    localparam int PW = AW + BW;
    localparam int CW = $clog2(BW + 1);

    typedef struct packed {
        logic [PW-1:0] acc;
        logic [PW-1:0] mcand;
        logic [BW-1:0] mplr;
        logic [CW-1:0] cnt;
    } mul_t;

    mul_t q, d;

    always_comb begin
        d = q;
        if (go) begin
            d.acc   = '0;
            d.mcand = PW'(a);
            d.mplr  = b;
            d.cnt   = CW'(BW);
        end else if (q.cnt != '0) begin
            if (q.mplr[0]) d.acc = q.acc + q.mcand;
            d.mcand = q.mcand << 1;
            d.mplr  = q.mplr >> 1;
            d.cnt   = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prod = q.acc;
    assign busy = (q.cnt != '0);
endmodule

// File: rtl/pdec_pow10.sv
// Sequential decimal scaler: value = mant * 10^expo, one decade per cycle.
module pdec_pow10 #(
    parameter int MW = 8,
    parameter int RW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [MW-1:0] mant,
    input  logic [3:0]    expo,
    output logic [RW-1:0] val,
    output logic          busy
);
    typedef struct packed {
        logic [RW-1:0] v;
        logic [3:0]    cnt;
    } p10_t;

    p10_t q, d;

    always_comb begin
        d = q;
        if (go) begin
            d.v   = RW'(mant);
            d.cnt = expo;
        end else if (q.cnt != 4'd0) begin
            d.v   = (q.v << 3) + (q.v << 1);
            d.cnt = q.cnt - 4'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign val  = q.v;
    assign busy = (q.cnt != 4'd0);
endmodule

// File: rtl/onfi_pdec.sv
module onfi_pdec
    import onfi_pdec_pkg::*;
#(
    parameter int          PGSZ_W   = 16,
    parameter int          PPB_W    = 16,
    parameter int          BLK_W    = 20,
    parameter logic [15:0] SUP_MASK = 16'h007E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic [7:0]           pg_addr,
    input  logic [7:0]           pg_data,
    output logic                 done,
    output logic [2:0]           err,
    output logic                 sig_valid,
    output logic [4:0]           bus_width,
    output logic [PGSZ_W-1:0]    page_size,
    output logic [15:0]          spare_size,
    output logic [PPB_W-1:0]     pages_per_blk,
    output logic [BLK_W+7:0]     total_blocks,
    output logic [23:0]          total_bad_max,
    output logic [31:0]          max_erase,
    output logic [7:0]           progs_per_page,
    output logic [7:0]           ecc_bits,
    output logic [9:0]           ecc_cw_size,
    output logic [7:0]           copy_count,
    output logic [19:0]          ext_page_len
);
    localparam int TBLK_W = BLK_W + 8;
    localparam int TBAD_W = 24;
    localparam int RW     = 40;
    localparam logic [15:0] GE21_MASK = SUP_MASK & 16'hFFF8;

    typedef struct packed {
        pdec_state_e         st;
        logic [7:0]          idx;
        logic                sig_ok;
        logic [15:0]         rev;
        logic                f_bus16;
        logic                f_ext;
        logic [15:0]         extl;
        logic [7:0]          copies;
        logic [31:0]         pgsz;
        logic [15:0]         spare;
        logic [31:0]         ppb;
        logic [31:0]         blk;
        logic [7:0]          lun;
        logic [15:0]         bad;
        logic [7:0]          mant;
        logic [7:0]          expo;
        logic [7:0]          nprog;
        logic [7:0]          ecc;
        logic                done;
        logic [2:0]          err;
        logic                o_sig;
        logic [4:0]          o_bw;
        logic [PGSZ_W-1:0]   o_pg;
        logic [15:0]         o_sp;
        logic [PPB_W-1:0]    o_ppb;
        logic [TBLK_W-1:0]   o_tblk;
        logic [TBAD_W-1:0]   o_tbad;
        logic [31:0]         o_erase;
        logic [7:0]          o_np;
        logic [7:0]          o_ecc;
        logic [9:0]          o_cw;
        logic [7:0]          o_cp;
        logic [19:0]         o_xl;
    } regs_t;

    regs_t q, d;

    logic              go;
    logic              exp_bad;
    logic [TBLK_W-1:0] blk_prod;
    logic [TBAD_W-1:0] bad_prod;
    logic [RW-1:0]     p10_val;
    logic              blk_busy, bad_busy, p10_busy;

    assign exp_bad = (q.expo > 8'(EXP_MAX));

    pdec_mul #(.AW(BLK_W), .BW(8)) u_blk_mul (
        .clk(clk), .rst_n(rst_n), .go(go),
        .a(q.blk[BLK_W-1:0]), .b(q.lun),
        .prod(blk_prod), .busy(blk_busy)
    );

    pdec_mul #(.AW(16), .BW(8)) u_bad_mul (
        .clk(clk), .rst_n(rst_n), .go(go),
        .a(q.bad), .b(q.lun),
        .prod(bad_prod), .busy(bad_busy)
    );

    pdec_pow10 #(.MW(8), .RW(RW)) u_p10 (
        .clk(clk), .rst_n(rst_n), .go(go),
        .mant(q.mant), .expo(exp_bad ? 4'd0 : q.expo[3:0]),
        .val(p10_val), .busy(p10_busy)
    );

    always_comb begin
        logic ver_bad, ge21, end_bad, rng_bad, ext_bad, ecc_ff;
        d       = q;
        d.done  = 1'b0;
        go      = 1'b0;
        ver_bad = q.rev[0] | ~|(q.rev & SUP_MASK);
        ge21    = |(q.rev & GE21_MASK);
        end_bad = exp_bad | (|p10_val[RW-1:32]);
        rng_bad = (|q.pgsz[31:PGSZ_W]) | (|q.ppb[31:PPB_W])
                | (|q.blk[31:BLK_W]) | end_bad;
        ecc_ff  = (q.ecc == 8'hFF);
        ext_bad = ecc_ff & ~q.f_ext;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st     = ST_SCAN;
                    d.idx    = '0;
                    d.sig_ok = 1'b1;
                end
            end
            ST_SCAN: begin
                if (q.idx <= 8'd3)
                    d.sig_ok = q.sig_ok & (pg_data == sig_char(q.idx[1:0]));
                case (q.idx)
                    8'd4:   d.rev[7:0]   = pg_data;
                    8'd5:   d.rev[15:8]  = pg_data;
                    8'd6: begin
                        d.f_bus16 = pg_data[0];
                        d.f_ext   = pg_data[7];
                    end
                    8'd12:  d.extl[7:0]  = pg_data;
                    8'd13:  d.extl[15:8] = pg_data;
                    8'd14:  d.copies     = pg_data;
                    8'd80, 8'd81, 8'd82, 8'd83:
                        d.pgsz[{q.idx[1:0], 3'b000} +: 8] = pg_data;
                    8'd84:  d.spare[7:0]  = pg_data;
                    8'd85:  d.spare[15:8] = pg_data;
                    8'd92, 8'd93, 8'd94, 8'd95:
                        d.ppb[{q.idx[1:0], 3'b000} +: 8] = pg_data;
                    8'd96, 8'd97, 8'd98, 8'd99:
                        d.blk[{q.idx[1:0], 3'b000} +: 8] = pg_data;
                    8'd100: d.lun        = pg_data;
                    8'd103: d.bad[7:0]   = pg_data;
                    8'd104: d.bad[15:8]  = pg_data;
                    8'd105: d.mant       = pg_data;
                    8'd106: d.expo       = pg_data;
                    8'd110: d.nprog      = pg_data;
                    8'd112: d.ecc        = pg_data;
                    default: ;
                endcase
                if (q.idx == LAST_IDX) begin
                    d.st = ST_MATH;
                    go   = 1'b1;
                end else begin
                    d.idx = q.idx + 8'd1;
                end
            end
            ST_MATH: begin
                if (!blk_busy && !bad_busy && !p10_busy) begin
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                    if (!q.sig_ok)    d.err = ERR_SIG;
                    else if (ver_bad) d.err = ERR_VER;
                    else if (rng_bad) d.err = ERR_RANGE;
                    else if (ext_bad) d.err = ERR_EXT;
                    else              d.err = ERR_NONE;
                    d.o_sig   = q.sig_ok;
                    d.o_bw    = q.f_bus16 ? 5'd16 : 5'd8;
                    d.o_pg    = q.pgsz[PGSZ_W-1:0];
                    d.o_sp    = q.spare;
                    d.o_ppb   = q.ppb[PPB_W-1:0];
                    d.o_tblk  = blk_prod;
                    d.o_tbad  = bad_prod;
                    d.o_erase = end_bad ? 32'd0 : p10_val[31:0];
                    d.o_np    = q.nprog;
                    d.o_ecc   = q.ecc;
                    d.o_cw    = ecc_ff ? 10'd0 : CW_NORMAL;
                    d.o_cp    = ge21 ? q.copies : 8'd3;
                    d.o_xl    = q.f_ext ? {q.extl, 4'b0000} : 20'd0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pg_addr        = q.idx;
    assign done           = q.done;
    assign err            = q.err;
    assign sig_valid      = q.o_sig;
    assign bus_width      = q.o_bw;
    assign page_size      = q.o_pg;
    assign spare_size     = q.o_sp;
    assign pages_per_blk  = q.o_ppb;
    assign total_blocks   = q.o_tblk;
    assign total_bad_max  = q.o_tbad;
    assign max_erase      = q.o_erase;
    assign progs_per_page = q.o_np;
    assign ecc_bits       = q.o_ecc;
    assign ecc_cw_size    = q.o_cw;
    assign copy_count     = q.o_cp;
    assign ext_page_len   = q.o_xl;
endmodule

// File: rtl/pdec_chk.sv
module pdec_chk #(
    parameter int PGSZ_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [2:0]        err,
    input logic              sig_valid,
    input logic [PGSZ_W-1:0] page_size,
    input logic [7:0]        pg_addr,
    input logic [7:0]        ecc_bits,
    input logic [9:0]        ecc_cw_size,
    input logic [31:0]       max_erase
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(page_size) && $stable(err) && $stable(max_erase)));

    // R11
    sig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sig_valid) |-> (err == 3'd1));

    // R10
    cw_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_bits == 8'hFF) |-> (ecc_cw_size == 10'd0));

    // R10
    cw_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ecc_bits != 8'hFF) |-> (ecc_cw_size == 10'd528));

    // R12
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_addr <= 8'd112);
endmodule

bind onfi_pdec pdec_chk #(.PGSZ_W(PGSZ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err(err),
    .sig_valid(sig_valid), .page_size(page_size), .pg_addr(pg_addr),
    .ecc_bits(ecc_bits), .ecc_cw_size(ecc_cw_size), .max_erase(max_erase)
);

// File: tb/sim_onfi_pdec.sv
module sim_onfi_pdec;
    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [7:0]  pg_addr, pg_data;
    logic        done, sig_valid;
    logic [2:0]  err;
    logic [4:0]  bus_width;
    logic [15:0] page_size, spare_size, pages_per_blk;
    logic [27:0] total_blocks;
    logic [23:0] total_bad_max;
    logic [31:0] max_erase;
    logic [7:0]  progs_per_page, ecc_bits, copy_count;
    logic [9:0]  ecc_cw_size;
    logic [19:0] ext_page_len;

    int total = 0;
    int bad   = 0;
    logic [7:0] max_addr = 8'd0;
    logic [7:0] mem [0:255];

    always #2 clk = ~clk;
    assign pg_data = mem[pg_addr];

    onfi_pdec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pg_addr(pg_addr),
        .pg_data(pg_data), .done(done), .err(err), .sig_valid(sig_valid),
        .bus_width(bus_width), .page_size(page_size), .spare_size(spare_size),
        .pages_per_blk(pages_per_blk), .total_blocks(total_blocks),
        .total_bad_max(total_bad_max), .max_erase(max_erase),
        .progs_per_page(progs_per_page), .ecc_bits(ecc_bits),
        .ecc_cw_size(ecc_cw_size), .copy_count(copy_count),
        .ext_page_len(ext_page_len)
    );

    typedef struct packed {
        logic [31:0] sig;
        logic [15:0] rev;
        logic [7:0]  feat;
        logic [15:0] extl;
        logic [7:0]  b14;
        logic [31:0] pgsz;
        logic [15:0] spare;
        logic [31:0] ppb;
        logic [31:0] blk;
        logic [7:0]  lun;
        logic [15:0] bad;
        logic [7:0]  mant;
        logic [7:0]  expo;
        logic [7:0]  nprog;
        logic [7:0]  ecc;
    } pg_t;

    typedef struct packed {
        logic [2:0]  err;
        logic        sig;
        logic [4:0]  bw;
        logic [15:0] pg;
        logic [15:0] sp;
        logic [15:0] ppb;
        logic [27:0] tb;
        logic [23:0] tbad;
        logic [31:0] er;
        logic [7:0]  np;
        logic [7:0]  ecc;
        logic [9:0]  cw;
        logic [7:0]  cp;
        logic [19:0] xl;
    } exp_t;

    exp_t expq[$];
    exp_t got;

    task automatic chk(input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic pg_t base_page();
        pg_t p;
        p.sig = 32'h49464E4F; p.rev = 16'h0002; p.feat = 8'h00;
        p.extl = 16'h0000; p.b14 = 8'h07; p.pgsz = 32'd2048;
        p.spare = 16'd128; p.ppb = 32'd64; p.blk = 32'd1024;
        p.lun = 8'd1; p.bad = 16'd20; p.mant = 8'd1; p.expo = 8'd5;
        p.nprog = 8'd4; p.ecc = 8'd0;
        return p;
    endfunction

    function automatic exp_t expect_of(pg_t p);
        exp_t e;
        longint er = longint'(p.mant);
        bit sig_ok, ver_bad, ge21, exp_bad, end_bad, rng, ext_bad;
        sig_ok  = (p.sig == 32'h49464E4F);
        ver_bad = p.rev[0] || ((p.rev & 16'h007E) == 16'h0);
        ge21    = ((p.rev & 16'h0078) != 16'h0);
        exp_bad = (p.expo > 8'd9);
        if (!exp_bad) for (int i = 0; i < int'(p.expo); i++) er = er * 10;
        end_bad = exp_bad || (er > 64'h0FFFFFFFF);
        rng     = (p.pgsz > 32'd65535) || (p.ppb > 32'd65535)
               || (p.blk > 32'h000FFFFF) || end_bad;
        ext_bad = (p.ecc == 8'hFF) && !p.feat[7];
        e.err  = !sig_ok ? 3'd1 : ver_bad ? 3'd2 : rng ? 3'd3 : ext_bad ? 3'd4 : 3'd0;
        e.sig  = sig_ok;
        e.bw   = p.feat[0] ? 5'd16 : 5'd8;
        e.pg   = p.pgsz[15:0];
        e.sp   = p.spare;
        e.ppb  = p.ppb[15:0];
        e.tb   = 28'(longint'(p.blk[19:0]) * longint'(p.lun));
        e.tbad = 24'(longint'(p.bad) * longint'(p.lun));
        e.er   = end_bad ? 32'd0 : er[31:0];
        e.np   = p.nprog;
        e.ecc  = p.ecc;
        e.cw   = (p.ecc == 8'hFF) ? 10'd0 : 10'd528;
        e.cp   = ge21 ? p.b14 : 8'd3;
        e.xl   = p.feat[7] ? {p.extl, 4'b0000} : 20'd0;
        return e;
    endfunction

    task automatic put_page(input pg_t p);
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            mem[k]      = p.sig[8*k +: 8];
            mem[80 + k] = p.pgsz[8*k +: 8];
            mem[92 + k] = p.ppb[8*k +: 8];
            mem[96 + k] = p.blk[8*k +: 8];
        end
        mem[4] = p.rev[7:0];    mem[5] = p.rev[15:8];
        mem[6] = p.feat;
        mem[12] = p.extl[7:0];  mem[13] = p.extl[15:8];
        mem[14] = p.b14;
        mem[84] = p.spare[7:0]; mem[85] = p.spare[15:8];
        mem[100] = p.lun;
        mem[103] = p.bad[7:0];  mem[104] = p.bad[15:8];
        mem[105] = p.mant;      mem[106] = p.expo;
        mem[110] = p.nprog;     mem[112] = p.ecc;
    endtask

    // driver: push the expected result, start a run, wait for it
    task automatic run(input pg_t p, input string tag);
        exp_t e;
        put_page(p);
        e = expect_of(p);
        expq.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R2", {tag, " done one cycle"}, longint'(done), 0);
        repeat (12) @(negedge clk);
        chk("R2", {tag, " page_size held"}, longint'(page_size), longint'(e.pg));
        chk("R2", {tag, " err held"}, longint'(err), longint'(e.err));
    endtask

    // monitor: compare the produced result against the queue head
    always @(negedge clk) begin
        if (rst_n && pg_addr > max_addr) max_addr = pg_addr;
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk("R2", "unexpected done", 1, 0);
            end else begin
                got = expq.pop_front();
                chk("R11", "err",            longint'(err),            longint'(got.err));
                chk("R3",  "sig_valid",      longint'(sig_valid),      longint'(got.sig));
                chk("R5",  "bus_width",      longint'(bus_width),      longint'(got.bw));
                chk("R6",  "page_size",      longint'(page_size),      longint'(got.pg));
                chk("R6",  "spare_size",     longint'(spare_size),     longint'(got.sp));
                chk("R6",  "pages_per_blk",  longint'(pages_per_blk),  longint'(got.ppb));
                chk("R7",  "total_blocks",   longint'(total_blocks),   longint'(got.tb));
                chk("R7",  "total_bad_max",  longint'(total_bad_max),  longint'(got.tbad));
                chk("R8",  "max_erase",      longint'(max_erase),      longint'(got.er));
                chk("R6",  "progs_per_page", longint'(progs_per_page), longint'(got.np));
                chk("R6",  "ecc_bits",       longint'(ecc_bits),       longint'(got.ecc));
                chk("R10", "ecc_cw_size",    longint'(ecc_cw_size),    longint'(got.cw));
                chk("R4",  "copy_count",     longint'(copy_count),     longint'(got.cp));
                chk("R5",  "ext_page_len",   longint'(ext_page_len),   longint'(got.xl));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("ALL", "watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pg_t p;
        rst_n = 1'b0;
        start = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", longint'(done), 0);
        chk("R1", "err after reset", longint'(err), 0);
        chk("R1", "bus_width after reset", longint'(bus_width), 0);
        chk("R1", "copy_count after reset", longint'(copy_count), 0);
        chk("R1", "max_erase after reset", longint'(max_erase), 0);

        // R6 R7 R8: plain legal page, revision 1.0 style
        p = base_page();
        run(p, "base");

        // R4 R5 R7 R10: revision 2.1, 16-bit bus, 4 LUNs, ECC in extended page
        p = base_page();
        p.rev = 16'h0008; p.b14 = 8'd5; p.feat = 8'h81; p.extl = 16'd3;
        p.lun = 8'd4; p.ecc = 8'hFF; p.mant = 8'd3; p.expo = 8'd4;
        run(p, "rev21");

        // R3 R11: signature broken
        p = base_page(); p.sig = 32'h49464E4E;
        run(p, "badsig");

        // R11: signature and version both broken, signature wins
        p = base_page(); p.sig = 32'h00464E4F; p.rev = 16'h0003;
        run(p, "sig+ver");

        // R4: bit 0 of revision set
        p = base_page(); p.rev = 16'h0005;
        run(p, "rev bit0");

        // R4: only an unsupported version bit
        p = base_page(); p.rev = 16'h0100;
        run(p, "rev unsup");

        // R8: exponent 10
        p = base_page(); p.expo = 8'd10;
        run(p, "exp10");

        // R8: 255 * 10^9 overflows 32 bits
        p = base_page(); p.mant = 8'd255; p.expo = 8'd9;
        run(p, "ovf");

        // R8: 4 * 10^9 still fits
        p = base_page(); p.mant = 8'd4; p.expo = 8'd9;
        run(p, "fit");

        // R9: page size one past the limit
        p = base_page(); p.pgsz = 32'd65536;
        run(p, "pgsz");

        // R9: blocks per LUN one past the limit
        p = base_page(); p.blk = 32'h00100000;
        run(p, "blk");

        // R10: ECC needs an extended page that is absent
        p = base_page(); p.ecc = 8'hFF;
        run(p, "noext");

        // R11: range outranks the extension fault
        p = base_page(); p.ecc = 8'hFF; p.expo = 8'd12;
        run(p, "rng+ext");

        // R7: largest block count and LUN count
        p = base_page(); p.blk = 32'h000FFFFF; p.lun = 8'd255; p.bad = 16'hFFFF;
        p.rev = 16'h0040; p.b14 = 8'd2;
        run(p, "maxlun");

        chk("R12", "highest pg_addr", longint'(max_addr), 112);
        chk("R2", "queue drained", longint'(expq.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule